// File: doc/BRIEF.md
# Mode-Selectable Audio Clock Divider

This block sits next to a stereo delta-sigma converter. It turns one master clock into the two slower clocks that the converter needs. The first is an oversampling clock at 128 times the word rate. The second is a serial bit clock at 64 times the word rate, which is half the oversampling clock. A ratio-select pin tells the block how fast the master clock runs:

- High means 384 times the word rate, so the block divides by three.
- Low means 256 times the word rate, so the block divides by two.

The pin is sampled only while the active-low power-down input is low. Any change while the block runs is ignored until the next power-down.

Power-down acts on the next master rising edge. That edge is edge 0 of the alignment count. Edge 1 is the first rising edge that samples power-down high.

After release, the dividers free-run from phase zero. The block then watches the left/right frame input for its first rising edge. That edge is detected on the master clock. The input must be low at edge k-1 and high at edge k; the rise is then said to arrive before edge k. On that edge the block freezes the divider phase for one or two master cycles, which pulls the oversampling clock back into line with the frame. A running flag reports that alignment is done.

Top module: `audio_clk_div`

## Requirements
- R1: On every master rising edge that samples power-down low, the oversampling clock, the bit clock and the running flag are driven low after that edge. The divider phase returns to zero, so the pattern after release always starts the same way.
- R2: With ratio select latched high, the oversampling clock has a period of three master cycles. It is high for one cycle and low for two. Without a frame rise it is high after release edges 3, 6, 9, and so on.
- R3: With ratio select latched low, the oversampling clock has a period of two master cycles at 50 % duty. Without a frame rise it is high after release edges 2, 4, and so on.
- R4: The bit clock toggles each time the divider phase wraps to zero. It therefore runs at half the oversampling clock, and it only changes level in a cycle in which the oversampling clock is high.
- R5: Ratio select is captured only on edges that sample power-down low. Changing it while power-down is high leaves the clock pattern unchanged.
- R6: In divide-by-three mode, a frame rise that arrives before edge 1 or edge 2 freezes the divider phase for one master cycle. The freeze starts at the edge where the rise is detected.
- R7: In divide-by-three mode, a frame rise that arrives before edge 3 or any later edge freezes the divider phase for two master cycles.
- R8: In divide-by-two mode, a frame rise freezes the divider phase for one master cycle, whichever edge it arrives before.
- R9: Only the first frame rise after release is used. Later rises do not disturb the clocks. A frame input that is already high at release does not count as a rise.
- R10: The running flag goes high after the last freeze cycle. It stays high until power-down is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| masterClk | input | 1 | Master clock; all logic uses its rising edge |
| pwrDnN | input | 1 | Active-low power-down, taken on the next rising edge |
| ratioSel | input | 1 | 1: master runs at 384 x word rate; 0: 256 x word rate |
| lrFrame | input | 1 | Left/right frame signal used for phase alignment |
| ovsClk | output | 1 | Oversampling clock, 128 x word rate |
| bitClk | output | 1 | Serial bit clock, 64 x word rate |
| running | output | 1 | High once alignment has completed |

## Verification
The hardest case to reach is the boundary between a one-cycle and a two-cycle freeze. Whether the freeze lasts one or two cycles depends only on which edge after release samples the frame input high for the first time. The bench therefore drives each release from a per-edge frame schedule, set up half a cycle before each master edge. This places the rise exactly before edge 2, edge 3 or edge 4. For each case, the bench compares the recorded per-edge output bits with patterns derived by hand from the requirements.

// File: rtl/audio_clk_pkg.sv
package audio_clk_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_ALIGN = 2'd2,
    ST_RUN   = 2'd3
  } ctlState_t;

  // Strobes passed from the control unit to the divider datapath.
  typedef struct packed {
    logic clear;  // force counters to zero, outputs low
    logic hold;   // freeze divider phase this edge
    logic div3;   // latched ratio: 1 = divide by three
  } ctrlStrb_t;

endpackage

// File: rtl/audio_clk_ctrl.sv
module audio_clk_ctrl
  import audio_clk_pkg::*;
#(
  parameter int EARLY_EDGE = 2,
  parameter int EARLY_PULL = 1,
  parameter int LATE_PULL  = 2
) (
  input  logic      clk,
  input  logic      pwrDnN,
  input  logic      ratioSel,
  input  logic      lrFrame,
  output ctrlStrb_t strb,
  output logic      running
);

  localparam int IDX_W  = $clog2(EARLY_EDGE + 2);
  localparam int PULL_W = $clog2(LATE_PULL + 1);
  localparam logic [IDX_W-1:0]  IDX_MAX   = IDX_W'(EARLY_EDGE + 1);
  localparam logic [IDX_W-1:0]  IDX_EARLY = IDX_W'(EARLY_EDGE);
  localparam logic [PULL_W-1:0] PULL_ONE  = PULL_W'(1);
  localparam logic [PULL_W-1:0] PULL_E    = PULL_W'(EARLY_PULL);
  localparam logic [PULL_W-1:0] PULL_L    = PULL_W'(LATE_PULL);

  ctlState_t         state;
  ctlState_t         stateNxt;
  logic              modeQ;
  logic              frameQ;
  logic [IDX_W-1:0]  edgeIdx;
  logic [IDX_W-1:0]  newIdx;
  logic [PULL_W-1:0] holdLeft;
  logic [PULL_W-1:0] holdLeftNxt;
  logic [PULL_W-1:0] pullAmt;
  logic              frameRise;
  logic              seeking;
  logic              holdNow;

  // Ratio select is captured only during power-down.
  always_ff @(posedge clk) begin
    if (!pwrDnN) modeQ <= ratioSel;
  end

  always_ff @(posedge clk) begin
    frameQ <= lrFrame;
  end

  assign frameRise = lrFrame & ~frameQ;
  assign newIdx    = (edgeIdx == IDX_MAX) ? edgeIdx : edgeIdx + 1'b1;

  // Edge index since power-down, saturating just past the early window.
  always_ff @(posedge clk) begin
    if (!pwrDnN) edgeIdx <= '0;
    else         edgeIdx <= newIdx;
  end

  always_comb begin
    if (!modeQ)                  pullAmt = PULL_ONE;
    else if (newIdx <= IDX_EARLY) pullAmt = PULL_E;
    else                          pullAmt = PULL_L;
  end

  assign seeking = (state == ST_IDLE) || (state == ST_WAIT);

  always_comb begin
    stateNxt    = state;
    holdLeftNxt = holdLeft;
    holdNow     = 1'b0;
    if (!pwrDnN) begin
      stateNxt    = ST_IDLE;
      holdLeftNxt = '0;
    end else begin
      case (state)
        ST_IDLE, ST_WAIT: begin
          if (frameRise) begin
            holdNow = 1'b1;
            if (pullAmt == PULL_ONE) begin
              stateNxt = ST_RUN;
            end else begin
              stateNxt    = ST_ALIGN;
              holdLeftNxt = pullAmt - PULL_ONE;
            end
          end else begin
            stateNxt = ST_WAIT;
          end
        end
        ST_ALIGN: begin
          holdNow     = 1'b1;
          holdLeftNxt = holdLeft - PULL_ONE;
          if (holdLeft == PULL_ONE) stateNxt = ST_RUN;
        end
        default: stateNxt = ST_RUN;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    state    <= stateNxt;
    holdLeft <= holdLeftNxt;
  end

  assign strb.clear = ~pwrDnN;
  assign strb.hold  = holdNow;
  assign strb.div3  = modeQ;
  assign running    = (state == ST_RUN);

  // R5: the latched ratio never moves while power-down is released.
  a_r5_mode_frozen: assert property (@(posedge clk) disable iff (!pwrDnN)
    1'b1 |=> $stable(modeQ));

  // R10: once running, the flag stays up until power-down.
  a_r10_running_holds: assert property (@(posedge clk) disable iff (!pwrDnN)
    running |=> running);

  // R9: no phase freeze is requested after alignment is complete.
  a_r9_no_hold_when_running: assert property (@(posedge clk) disable iff (!pwrDnN)
    running |-> !strb.hold);

  // R6/R7/R8: a freeze is requested only while seeking or aligning.
  a_r7_hold_source: assert property (@(posedge clk) disable iff (!pwrDnN)
    strb.hold |-> (seeking || state == ST_ALIGN));

endmodule

// File: rtl/audio_clk_dpath.sv
module audio_clk_dpath
  import audio_clk_pkg::*;
#(
  parameter int DIV_FAST = 3,
  parameter int DIV_SLOW = 2
) (
  input  logic      clk,
  input  ctrlStrb_t strb,
  output logic      ovsClk,
  output logic      bitClk
);

  localparam int PH_W = (DIV_FAST > 2) ? $clog2(DIV_FAST) : 1;
  localparam logic [PH_W-1:0] LAST_FAST = PH_W'(DIV_FAST - 1);
  localparam logic [PH_W-1:0] LAST_SLOW = PH_W'(DIV_SLOW - 1);

  logic [PH_W-1:0] phase;
  logic [PH_W-1:0] lastPh;
  logic            wrap;
  logic            bitPh;
  logic            enQ;

  assign lastPh = strb.div3 ? LAST_FAST : LAST_SLOW;
  assign wrap   = !strb.clear && !strb.hold && (phase == lastPh);

  always_ff @(posedge clk) begin
    if (strb.clear)     phase <= '0;
    else if (strb.hold) phase <= phase;
    else if (wrap)      phase <= '0;
    else                phase <= phase + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (strb.clear) bitPh <= 1'b0;
    else if (wrap)  bitPh <= ~bitPh;
  end

  always_ff @(posedge clk) begin
    enQ <= ~strb.clear;
  end

  assign ovsClk = enQ & (phase == '0);
  assign bitClk = enQ & bitPh;

  // R1: a power-down edge leaves both clocks low.
  a_r1_quiet_after_pd: assert property (@(posedge clk)
    strb.clear |=> (!ovsClk && !bitClk));

  // R2/R3: the phase never leaves the range of the latched ratio.
  a_r2_phase_in_range: assert property (@(posedge clk) disable iff (strb.clear)
    phase <= lastPh);

  // R6: a freeze strobe keeps the phase unchanged across the edge.
  a_r6_hold_freezes: assert property (@(posedge clk) disable iff (strb.clear)
    strb.hold |=> $stable(phase));

  // R4: the bit clock only changes while the oversampling clock is high.
  a_r4_bclk_rise: assert property (@(posedge clk) disable iff (strb.clear)
    $rose(bitClk) |-> ovsClk);
  a_r4_bclk_fall: assert property (@(posedge clk) disable iff (strb.clear)
    $fell(bitClk) |-> ovsClk);

endmodule

// File: rtl/audio_clk_div.sv
module audio_clk_div
  import audio_clk_pkg::*;
#(
  parameter int DIV_FAST   = 3,
  parameter int DIV_SLOW   = 2,
  parameter int EARLY_EDGE = 2,
  parameter int EARLY_PULL = 1,
  parameter int LATE_PULL  = 2
) (
  input  logic masterClk,
  input  logic pwrDnN,
  input  logic ratioSel,
  input  logic lrFrame,
  output logic ovsClk,
  output logic bitClk,
  output logic running
);

  ctrlStrb_t strb;

  audio_clk_ctrl #(
    .EARLY_EDGE(EARLY_EDGE),
    .EARLY_PULL(EARLY_PULL),
    .LATE_PULL (LATE_PULL)
  ) u_ctrl (
    .clk     (masterClk),
    .pwrDnN  (pwrDnN),
    .ratioSel(ratioSel),
    .lrFrame (lrFrame),
    .strb    (strb),
    .running (running)
  );

  audio_clk_dpath #(
    .DIV_FAST(DIV_FAST),
    .DIV_SLOW(DIV_SLOW)
  ) u_dpath (
    .clk   (masterClk),
    .strb  (strb),
    .ovsClk(ovsClk),
    .bitClk(bitClk)
  );

endmodule

// File: tb/test_audio_clk_div.sv
module test_audio_clk_div;

  localparam int CLK_PERIOD = 10;

  logic masterClk = 1'b0;
  logic pwrDnN    = 1'b0;
  logic ratioSel  = 1'b1;
  logic lrFrame   = 1'b0;
  logic ovsClk;
  logic bitClk;
  logic running;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD / 2) masterClk = ~masterClk;

  audio_clk_div i_audio_clk_div (
    .masterClk(masterClk),
    .pwrDnN   (pwrDnN),
    .ratioSel (ratioSel),
    .lrFrame  (lrFrame),
    .ovsClk   (ovsClk),
    .bitClk   (bitClk),
    .running  (running)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge masterClk);
    @(negedge masterClk);
  endtask

  // Two power-down edges; each must leave all outputs low (R1).
  task automatic enterPd(input logic mode, input logic frameLvl);
    pwrDnN   = 1'b0;
    ratioSel = mode;
    lrFrame  = frameLvl;
    for (int i = 0; i < 2; i++) begin
      step();
      chk("R1 outputs low in power-down", {29'd0, ovsClk, bitClk, running}, 32'd0);
    end
  endtask

  // Release, then run n edges; bit k of frSched is the frame level set up
  // before edge k. Bit k of each result is the output after edge k.
  task automatic runSeq(input int n, input logic [31:0] frSched, input int modeFlipAt,
                        output logic [31:0] oSeq, output logic [31:0] bSeq,
                        output logic [31:0] rSeq);
    oSeq = '0; bSeq = '0; rSeq = '0;
    pwrDnN = 1'b1;
    for (int k = 1; k <= n; k++) begin
      lrFrame = frSched[k];
      if (k == modeFlipAt) ratioSel = ~ratioSel;
      step();
      oSeq[k] = ovsClk;
      bSeq[k] = bitClk;
      rSeq[k] = running;
    end
  endtask

  task automatic testDiv3Free();
    logic [31:0] o, b, r;
    enterPd(1'b1, 1'b0);
    runSeq(6, 32'd0, 0, o, b, r);
    chk("R2 div3 free-running ovsClk", o, 32'h48);
    chk("R4 div3 bitClk half rate", b, 32'h38);
    chk("R10 no running without frame", r, 32'h0);
  endtask

  task automatic testDiv3Early();
    logic [31:0] o, b, r;
    enterPd(1'b1, 1'b0);
    runSeq(7, 32'hFFFF_FFFC, 0, o, b, r);
    chk("R6 early frame one-cycle hold", o, 32'h90);
    chk("R4 bitClk after early align", b, 32'h70);
    chk("R10 running after early align", r, 32'hFC);
  endtask

  task automatic testDiv3Boundary();
    logic [31:0] o, b, r;
    enterPd(1'b1, 1'b0);
    runSeq(5, 32'hFFFF_FFF8, 0, o, b, r);
    chk("R7 frame before edge 3 two-cycle hold", o, 32'h20);
    chk("R10 running after boundary align", r, 32'h30);
  endtask

  task automatic testDiv3Late();
    logic [31:0] o, b, r;
    enterPd(1'b1, 1'b0);
    runSeq(8, 32'hFFFF_FFF0, 0, o, b, r);
    chk("R7 late frame two-cycle hold", o, 32'h138);
    chk("R10 running after late align", r, 32'h1E0);
  endtask

  task automatic testDiv2();
    logic [31:0] o, b, r;
    enterPd(1'b0, 1'b0);
    runSeq(4, 32'd0, 0, o, b, r);
    chk("R3 div2 free-running ovsClk", o, 32'h14);
    chk("R4 div2 bitClk half rate", b, 32'h0C);
    enterPd(1'b0, 1'b0);
    runSeq(5, 32'hFFFF_FFF8, 0, o, b, r);
    chk("R8 div2 frame before edge 3", o, 32'h2C);
    chk("R10 div2 running", r, 32'h38);
    enterPd(1'b0, 1'b0);
    runSeq(5, 32'hFFFF_FFF0, 0, o, b, r);
    chk("R8 div2 late frame still one cycle", o, 32'h24);
    chk("R10 div2 running late", r, 32'h30);
  endtask

  task automatic testSecondRise();
    logic [31:0] o, b, r;
    enterPd(1'b1, 1'b0);
    runSeq(13, 32'hFFFF_FEFC, 0, o, b, r);
    chk("R9 second frame rise ignored", o, 32'h2490);
    chk("R10 running stays high", r, 32'h3FFC);
    enterPd(1'b1, 1'b1);
    runSeq(6, 32'hFFFF_FFFF, 0, o, b, r);
    chk("R9 frame high at release is no rise", o, 32'h48);
    chk("R9 no running without a rise", r, 32'h0);
  endtask

  task automatic testModeChange();
    logic [31:0] o, b, r;
    enterPd(1'b1, 1'b0);
    runSeq(10, 32'hFFFF_FFFC, 5, o, b, r);
    chk("R5 ratio change while running ignored", o, 32'h490);
    enterPd(ratioSel, 1'b0);
    runSeq(4, 32'd0, 0, o, b, r);
    chk("R5 new ratio taken in power-down", o, 32'h14);
  endtask

  initial begin
    @(negedge masterClk);
    chk("R1 reset state", {29'd0, ovsClk, bitClk, running}, 32'd0);
    testDiv3Free();
    testDiv3Early();
    testDiv3Boundary();
    testDiv3Late();
    testDiv2();
    testSecondRise();
    testModeChange();
    enterPd(1'b1, 1'b0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule